// File: doc/BRIEF.md
# Interrupt Source Gating and Routing

This block keeps the configuration and live state of every interrupt input in a controller. Each source has a vector/priority word and a destination word. The block watches the raw inputs, keeps a pending flag and an in-service activity flag for each source, and decides when a source may be delivered. A delivered source is recorded in a per-CPU "raised" set. A one-cycle strobe tells each CPU port that something new arrived there.

Firmware configures sources through a word-wide port that selects a source index and one of its two words; the selected word reads back combinationally. Each CPU's current task priority arrives as an input from the per-CPU logic. An acknowledge path removes a source from a CPU's raised set. Whether a source is level- or edge-sensed is fixed at build time for each source. Delivery is directed: every CPU selected in the destination word is considered on its own.

Top module: `isr_route`

## Requirements
- R1: After reset, every vector/priority word reads 0xA0000000 with bit 22 additionally set for level-sensed sources, every destination word reads 0, no raised bit is set and both strobes are low.
- R2: A vector/priority write changes only bits 31 (mask), 19:16 (priority) and 7:0 (vector). Bit 30 (activity) keeps its value. Bit 29 always reads 1, bit 23 reads 0, bit 22 reads the source's sense, and all other bits read 0.
- R3: A destination write stores bits 31:30 and the low NUM_CPU bits (bit c selects CPU c) and reads zero in all other bits.
- R4: For a level-sensed source, pending equals the last input level. A falling input clears activity.
- R5: For an edge-sensed source, a rising input sets pending, and a falling input leaves pending as it was.
- R6: No delivery happens while pending is clear, the mask bit is 1, priority is 0, activity is 1, or no CPU is selected.
- R7: For each selected CPU c, delivery happens only when the source priority is strictly greater than task_prio[4c+3:4c] and raised bit c*NUM_SRC+s is clear. A delivery sets that raised bit and the activity bit at the next clock edge, and raise_stb[c] is high for exactly that one following cycle.
- R8: Delivery is evaluated only in a cycle where the source's input differs from its previous sampled value, or where its vector/priority word is written. Destination writes and task-priority changes alone never deliver.
- R9: An acknowledge (ack_valid with ack_cpu, ack_src) clears raised bit ack_cpu*NUM_SRC+ack_src at the next edge. For an edge-sensed source it also clears activity and pending. For a level-sensed source it leaves both unchanged. An acknowledge applies before the same cycle's delivery evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Raw interrupt inputs, active high |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_dst_sel | input | 1 | 0 selects the vector/priority word, 1 the destination word |
| cfg_idx | input | IDX_W | Source index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Selected word of the indexed source (combinational) |
| task_prio | input | 4*NUM_CPU | Current task priority per CPU, CPU c at bits 4c+3:4c |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_cpu | input | CPU_W | CPU being acknowledged |
| ack_src | input | IDX_W | Source being acknowledged |
| raised | output | NUM_CPU*NUM_SRC | Raised set, bit c*NUM_SRC+s |
| raise_stb | output | NUM_CPU | One-cycle pulse per CPU on a new delivery |

## Verification
Every stateful result appears at the first rising edge after the stimulus that causes it: raised bits, activity, pending, stored words and raise_stb all come from one register stage. The readback is combinational on the index, so it shows the post-edge state in the same cycle. The bench changes inputs at the falling edge and samples 1 ns after the next rising edge, where a reference model stepped once per edge gives the expected raised set, strobes and readback. Hidden pending state is brought out through later vector writes that re-trigger evaluation.

// File: rtl/isr_pkg.sv
// Package: field positions and fixed values of the per-source words.
// Assumes 32-bit configuration words and a 4-bit priority field.
package isr_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned PRIO_W   = 4;
    localparam int unsigned VEC_W    = 8;
    localparam int unsigned B_MASK   = 31;
    localparam int unsigned B_ACT    = 30;
    localparam int unsigned B_MODE   = 29;
    localparam int unsigned B_POL    = 23;
    localparam int unsigned B_SENSE  = 22;
    localparam int unsigned PRIO_LO  = 16;
    localparam int unsigned DHI_LO   = 30;

    // Assemble the readable vector/priority word from its stored fields.
    function automatic logic [WORD_W-1:0] build_vp(
        input logic              masked,
        input logic              active,
        input logic              level,
        input logic [PRIO_W-1:0] prio,
        input logic [VEC_W-1:0]  vec
    );
        logic [WORD_W-1:0] w;
        w                           = '0;
        w[B_MASK]                   = masked;
        w[B_ACT]                    = active;
        w[B_MODE]                   = 1'b1;
        w[B_POL]                    = 1'b0;
        w[B_SENSE]                  = level;
        w[PRIO_LO +: PRIO_W]        = prio;
        w[VEC_W-1:0]                = vec;
        return w;
    endfunction
endpackage

// File: rtl/isr_slot.sv
// Module: isr_slot
// One interrupt source: stores its mask, priority, vector, destination,
// pending and activity state and its raised bit at every CPU, and decides
// delivery when its input changes or its vector word is written.
// Assumes: task priorities are stable during the cycle; sense is fixed at
// build time through IS_LEVEL.
module isr_slot #(
    parameter int unsigned NUM_CPU  = 2,
    parameter bit          IS_LEVEL = 1'b0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               irq,
    input  logic                               wr_vp,
    input  logic                               wr_dst,
    input  logic                               w_mask,
    input  logic [isr_pkg::PRIO_W-1:0]         w_prio,
    input  logic [isr_pkg::VEC_W-1:0]          w_vec,
    input  logic [1:0]                         w_dhi,
    input  logic [NUM_CPU-1:0]                 w_dsel,
    input  logic [NUM_CPU*isr_pkg::PRIO_W-1:0] task_prio,
    input  logic [NUM_CPU-1:0]                 ack_hit,
    output logic [isr_pkg::WORD_W-1:0]         vp_word,
    output logic [isr_pkg::WORD_W-1:0]         dst_word,
    output logic [NUM_CPU-1:0]                 raised_o,
    output logic [NUM_CPU-1:0]                 hit_o
);
    import isr_pkg::*;

    localparam int unsigned DST_GAP = WORD_W - 2 - NUM_CPU;

    logic                 irq_q, msk_q, act_q, pend_q;
    logic [PRIO_W-1:0]    prio_q;
    logic [VEC_W-1:0]     vec_q;
    logic [1:0]           dhi_q;
    logic [NUM_CPU-1:0]   dsel_q, raised_q;

    logic                 msk_n, act_b, pend_b, chg, allow;
    logic [PRIO_W-1:0]    prio_n;
    logic [VEC_W-1:0]     vec_n;
    logic [NUM_CPU-1:0]   raised_a, hit;

    // Next-state fields, acknowledge and input sensing, then delivery decision.
    always_comb begin
        msk_n    = wr_vp ? w_mask : msk_q;
        prio_n   = wr_vp ? w_prio : prio_q;
        vec_n    = wr_vp ? w_vec  : vec_q;
        raised_a = raised_q & ~ack_hit;
        act_b    = act_q;
        pend_b   = pend_q;
        if ((|ack_hit) && !IS_LEVEL) begin
            act_b  = 1'b0;
            pend_b = 1'b0;
        end
        chg = irq ^ irq_q;
        if (chg) begin
            if (IS_LEVEL) begin
                pend_b = irq;
                if (!irq) act_b = 1'b0;
            end else if (irq) begin
                pend_b = 1'b1;
            end
        end
        allow = (chg | wr_vp) & pend_b & ~msk_n & (prio_n != '0) & ~act_b & (|dsel_q);
        for (int c = 0; c < int'(NUM_CPU); c++) begin
            hit[c] = allow & dsel_q[c] & ~raised_a[c]
                   & (prio_n > task_prio[c*PRIO_W +: PRIO_W]);
        end
    end

    // State update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q    <= 1'b0;
            msk_q    <= 1'b1;
            act_q    <= 1'b0;
            pend_q   <= 1'b0;
            prio_q   <= '0;
            vec_q    <= '0;
            dhi_q    <= '0;
            dsel_q   <= '0;
            raised_q <= '0;
        end else begin
            irq_q    <= irq;
            msk_q    <= msk_n;
            prio_q   <= prio_n;
            vec_q    <= vec_n;
            pend_q   <= pend_b;
            act_q    <= act_b | (|hit);
            raised_q <= raised_a | hit;
            if (wr_dst) begin
                dhi_q  <= w_dhi;
                dsel_q <= w_dsel;
            end
        end
    end

    assign vp_word  = build_vp(msk_q, act_q, IS_LEVEL, prio_q, vec_q);
    assign dst_word = {dhi_q, {DST_GAP{1'b0}}, dsel_q};
    assign raised_o = raised_q;
    assign hit_o    = hit;
endmodule

// File: rtl/isr_readback.sv
// Module: isr_readback
// Selects one source's vector/priority or destination word for reading.
// Assumes: an index beyond the last source reads as zero.
module isr_readback #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned IDX_W   = 6
) (
    input  logic [NUM_SRC*32-1:0] vp_all,
    input  logic [NUM_SRC*32-1:0] dst_all,
    input  logic                  sel_dst,
    input  logic [IDX_W-1:0]      idx,
    output logic [31:0]           rdata
);
    // Index-driven word selection.
    always_comb begin
        rdata = '0;
        for (int s = 0; s < int'(NUM_SRC); s++) begin
            if (int'(idx) == s) rdata = sel_dst ? dst_all[s*32 +: 32] : vp_all[s*32 +: 32];
        end
    end
endmodule

// File: rtl/isr_strobe.sv
// Module: isr_strobe
// Reduces this cycle's per-source delivery decisions into one registered
// pulse per CPU. Assumes hits are laid out CPU-major (c*NUM_SRC+s).
module isr_strobe #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned NUM_CPU = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CPU*NUM_SRC-1:0] hit_all,
    output logic [NUM_CPU-1:0]         stb
);
    // One pulse per CPU in the cycle after any new delivery there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb <= '0;
        end else begin
            for (int c = 0; c < int'(NUM_CPU); c++) begin
                stb[c] <= |hit_all[c*NUM_SRC +: NUM_SRC];
            end
        end
    end
endmodule

// File: rtl/isr_route.sv
// Module: isr_route (top)
// Per-source interrupt gating and directed routing to NUM_CPU ports.
// Assumes: at most one configuration write and one acknowledge per cycle;
// SRC_LEVEL bit s marks source s as level-sensed.
module isr_route #(
    parameter int unsigned       NUM_SRC   = 64,
    parameter int unsigned       NUM_CPU   = 2,
    parameter logic [NUM_SRC-1:0] SRC_LEVEL = '0,
    localparam int unsigned      IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int unsigned      CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         irq_in,
    input  logic                       cfg_we,
    input  logic                       cfg_dst_sel,
    input  logic [IDX_W-1:0]           cfg_idx,
    input  logic [31:0]                cfg_wdata,
    output logic [31:0]                cfg_rdata,
    input  logic [NUM_CPU*4-1:0]       task_prio,
    input  logic                       ack_valid,
    input  logic [CPU_W-1:0]           ack_cpu,
    input  logic [IDX_W-1:0]           ack_src,
    output logic [NUM_CPU*NUM_SRC-1:0] raised,
    output logic [NUM_CPU-1:0]         raise_stb
);
    import isr_pkg::*;

    logic [NUM_SRC*32-1:0]      vp_all, dst_all;
    logic [NUM_CPU*NUM_SRC-1:0] hit_all;

    generate
        for (genvar s = 0; s < int'(NUM_SRC); s++) begin : g_src
            logic                 sel_me;
            logic [NUM_CPU-1:0]   ack_me, r_me, h_me;
            assign sel_me = cfg_we && (int'(cfg_idx) == s);
            for (genvar c = 0; c < int'(NUM_CPU); c++) begin : g_cpu
                assign ack_me[c] = ack_valid && (int'(ack_src) == s) && (int'(ack_cpu) == c);
                assign raised[c*NUM_SRC + s]  = r_me[c];
                assign hit_all[c*NUM_SRC + s] = h_me[c];
            end
            isr_slot #(
                .NUM_CPU  (NUM_CPU),
                .IS_LEVEL (SRC_LEVEL[s])
            ) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .irq       (irq_in[s]),
                .wr_vp     (sel_me && !cfg_dst_sel),
                .wr_dst    (sel_me && cfg_dst_sel),
                .w_mask    (cfg_wdata[B_MASK]),
                .w_prio    (cfg_wdata[PRIO_LO +: PRIO_W]),
                .w_vec     (cfg_wdata[VEC_W-1:0]),
                .w_dhi     (cfg_wdata[DHI_LO +: 2]),
                .w_dsel    (cfg_wdata[NUM_CPU-1:0]),
                .task_prio (task_prio),
                .ack_hit   (ack_me),
                .vp_word   (vp_all[s*32 +: 32]),
                .dst_word  (dst_all[s*32 +: 32]),
                .raised_o  (r_me),
                .hit_o     (h_me)
            );
        end
    endgenerate

    isr_readback #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_rd (
        .vp_all  (vp_all),
        .dst_all (dst_all),
        .sel_dst (cfg_dst_sel),
        .idx     (cfg_idx),
        .rdata   (cfg_rdata)
    );

    isr_strobe #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_stb (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_all (hit_all),
        .stb     (raise_stb)
    );
endmodule

// File: rtl/isr_route_chk.sv
// Module: isr_route_chk
// Port-level properties of isr_route, attached by bind below.
module isr_route_chk #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned NUM_CPU = 2,
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned CPU_W   = 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_dst_sel,
    input logic [IDX_W-1:0]           cfg_idx,
    input logic [31:0]                cfg_rdata,
    input logic                       ack_valid,
    input logic [CPU_W-1:0]           ack_cpu,
    input logic [IDX_W-1:0]           ack_src,
    input logic [NUM_CPU*NUM_SRC-1:0] raised,
    input logic [NUM_CPU-1:0]         raise_stb
);
    // R1: leaving reset, nothing is raised and no strobe is active.
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (raised == '0 && raise_stb == '0));

    // R2: fixed bits of a readable vector/priority word.
    assert_vp_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dst_sel && int'(cfg_idx) < int'(NUM_SRC)) |->
        (cfg_rdata[29] && !cfg_rdata[23] && cfg_rdata[21:20] == 2'b00 && cfg_rdata[15:8] == 8'h00));

    // R3: unused destination bits read zero.
    assert_dst_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dst_sel |-> (cfg_rdata[29:NUM_CPU] == '0));

    generate
        for (genvar c = 0; c < int'(NUM_CPU); c++) begin : g_c
            // R7: a strobe always comes with something raised at that CPU.
            assert_stb_raised_R7: assert property (@(posedge clk) disable iff (!rst_n)
                raise_stb[c] |-> (|raised[c*NUM_SRC +: NUM_SRC]));
            for (genvar s = 0; s < int'(NUM_SRC); s++) begin : g_s
                // R7: a newly raised bit is announced by the strobe.
                assert_rise_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(raised[c*NUM_SRC + s]) |-> raise_stb[c]);
                // R9: a raised bit only drops after a matching acknowledge.
                assert_fall_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
                    $fell(raised[c*NUM_SRC + s]) |->
                    $past(ack_valid && int'(ack_cpu) == c && int'(ack_src) == s));
            end
        end
    endgenerate
endmodule

bind isr_route isr_route_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU),
    .IDX_W   (IDX_W),
    .CPU_W   (CPU_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_dst_sel (cfg_dst_sel),
    .cfg_idx     (cfg_idx),
    .cfg_rdata   (cfg_rdata),
    .ack_valid   (ack_valid),
    .ack_cpu     (ack_cpu),
    .ack_src     (ack_src),
    .raised      (raised),
    .raise_stb   (raise_stb)
);

// File: tb/sim_isr_route.sv
`timescale 1ns/1ps
module sim_isr_route;
    localparam int NS = 16;
    localparam int NC = 2;
    localparam int IW = 4;
    localparam int CW = 1;
    localparam logic [NS-1:0] LVL = 16'hF0F0;

    logic            clk = 0;
    logic            rst_n = 0;
    logic [NS-1:0]   irq_in = '0;
    logic            cfg_we = 0, cfg_dst_sel = 0;
    logic [IW-1:0]   cfg_idx = '0;
    logic [31:0]     cfg_wdata = '0, cfg_rdata;
    logic [NC*4-1:0] task_prio = '0;
    logic            ack_valid = 0;
    logic [CW-1:0]   ack_cpu = '0;
    logic [IW-1:0]   ack_src = '0;
    logic [NC*NS-1:0] raised;
    logic [NC-1:0]   raise_stb;

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    isr_route #(.NUM_SRC(NS), .NUM_CPU(NC), .SRC_LEVEL(LVL)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
        .cfg_dst_sel(cfg_dst_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .task_prio(task_prio), .ack_valid(ack_valid),
        .ack_cpu(ack_cpu), .ack_src(ack_src), .raised(raised), .raise_stb(raise_stb));

    // Reference state, stepped once per rising edge.
    bit              m_mask[NS], m_act[NS], m_pend[NS], m_irq[NS];
    bit [3:0]        m_prio[NS];
    bit [7:0]        m_vec[NS];
    bit [1:0]        m_dhi[NS];
    bit [NC-1:0]     m_dsel[NS];
    bit [NC*NS-1:0]  m_raised;
    bit [NC-1:0]     m_stb;

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(bit sel, int s);
        if (sel) return {m_dhi[s], 28'h0, m_dsel[s]};
        return {m_mask[s], m_act[s], 1'b1, 5'b0, 1'b0, LVL[s], 2'b0, m_prio[s], 8'h00, m_vec[s]};
    endfunction

    task automatic model_edge();
        bit [NC*NS-1:0] r_n;
        bit [NC-1:0]    s_n;
        r_n = m_raised;
        s_n = '0;
        if (ack_valid) r_n[int'(ack_cpu)*NS + int'(ack_src)] = 1'b0;
        for (int s = 0; s < NS; s++) begin
            bit wv, mk, ac, pe, chg, any;
            bit [3:0] pr;
            bit [7:0] vc;
            wv = cfg_we && !cfg_dst_sel && int'(cfg_idx) == s;
            mk = wv ? cfg_wdata[31] : m_mask[s];
            pr = wv ? cfg_wdata[19:16] : m_prio[s];
            vc = wv ? cfg_wdata[7:0] : m_vec[s];
            ac = m_act[s];
            pe = m_pend[s];
            if (ack_valid && int'(ack_src) == s && !LVL[s]) begin ac = 0; pe = 0; end
            chg = (irq_in[s] != m_irq[s]);
            if (chg) begin
                if (LVL[s]) begin pe = irq_in[s]; if (!irq_in[s]) ac = 0; end
                else if (irq_in[s]) pe = 1;
            end
            any = 0;
            if ((chg || wv) && pe && !mk && pr != 0 && !ac && m_dsel[s] != 0) begin
                for (int c = 0; c < NC; c++) begin
                    if (m_dsel[s][c] && pr > task_prio[c*4 +: 4] && !r_n[c*NS+s]) begin
                        r_n[c*NS+s] = 1; s_n[c] = 1; any = 1;
                    end
                end
            end
            if (any) ac = 1;
            m_mask[s] = mk; m_prio[s] = pr; m_vec[s] = vc; m_act[s] = ac; m_pend[s] = pe;
            if (cfg_we && cfg_dst_sel && int'(cfg_idx) == s) begin
                m_dhi[s]  = cfg_wdata[31:30];
                m_dsel[s] = cfg_wdata[NC-1:0];
            end
            m_irq[s] = irq_in[s];
        end
        m_raised = r_n;
        m_stb    = s_n;
    endtask

    // One clock: model step, sample after the edge, release one-shot inputs.
    task automatic step(string tag);
        model_edge();
        @(posedge clk); #1;
        chk(tag, "raised", 64'(raised), 64'(m_raised));
        chk(tag, "raise_stb", 64'(raise_stb), 64'(m_stb));
        chk(tag, "rdata", 64'(cfg_rdata), 64'(exp_rd(cfg_dst_sel, int'(cfg_idx))));
        @(negedge clk);
        cfg_we = 0; ack_valid = 0;
    endtask

    task automatic wr_vp(int s, logic [31:0] v, string tag);
        cfg_we = 1; cfg_dst_sel = 0; cfg_idx = IW'(s); cfg_wdata = v; step(tag);
    endtask
    task automatic wr_dst(int s, logic [31:0] v, string tag);
        cfg_we = 1; cfg_dst_sel = 1; cfg_idx = IW'(s); cfg_wdata = v; step(tag);
    endtask
    task automatic peek(bit sel, int s, string tag);
        cfg_dst_sel = sel; cfg_idx = IW'(s); step(tag);
    endtask
    task automatic set_irq(int s, bit v, string tag);
        irq_in[s] = v; step(tag);
    endtask
    task automatic ack(int c, int s, string tag);
        ack_valid = 1; ack_cpu = CW'(c); ack_src = IW'(s); step(tag);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int s = 0; s < NS; s++) begin
            m_mask[s] = 1; m_act[s] = 0; m_pend[s] = 0; m_irq[s] = 0;
            m_prio[s] = 0; m_vec[s] = 0; m_dhi[s] = 0; m_dsel[s] = 0;
        end
        m_raised = '0; m_stb = '0;
        repeat (3) @(negedge clk);
        chk("R1", "raised in reset", 64'(raised), 64'h0);
        rst_n = 1;

        // R1: reset values of every word.
        for (int s = 0; s < NS; s++) begin
            peek(0, s, "R1");
            chk("R1", "vp reset", 64'(cfg_rdata), 64'(32'hA000_0000 | (32'(LVL[s]) << 22)));
            peek(1, s, "R1");
            chk("R1", "dst reset", 64'(cfg_rdata), 64'h0);
        end

        // R2: writable bits only.
        wr_vp(3, 32'hFFFF_FFFF, "R2");
        chk("R2", "vp edge src", 64'(cfg_rdata), 64'hA00F_00FF);
        wr_vp(5, 32'hFFFF_FFFF, "R2");
        chk("R2", "vp level src", 64'(cfg_rdata), 64'hA04F_00FF);
        wr_vp(3, 32'h8000_0000, "R2");
        wr_vp(5, 32'h8000_0000, "R2");

        // R3: destination bits.
        wr_dst(3, 32'hFFFF_FFFF, "R3");
        chk("R3", "dst all ones", 64'(cfg_rdata), 64'hC000_0003);
        wr_dst(3, 32'h0, "R3");

        // Edge source 2 to CPU0.
        wr_dst(2, 32'h1, "R6");
        wr_vp(2, 32'h0005_0022, "R6");
        chk("R6", "no pending no raise", 64'(raise_stb), 64'h0);
        set_irq(2, 1, "R5");
        chk("R7", "edge raise bit", 64'(raised[2]), 64'h1);
        chk("R7", "edge strobe", 64'(raise_stb), 64'h1);
        peek(0, 2, "R7");
        chk("R7", "activity set", 64'(cfg_rdata), 64'h6005_0022);
        chk("R7", "strobe one cycle", 64'(raise_stb), 64'h0);
        set_irq(2, 0, "R5");
        wr_vp(2, 32'h0005_0022, "R6");
        chk("R6", "active suppresses", 64'(raise_stb), 64'h0);
        ack(0, 2, "R9");
        chk("R9", "ack clears raised", 64'(raised[2]), 64'h0);
        chk("R9", "ack clears activity", 64'(cfg_rdata), 64'h2005_0022);
        wr_vp(2, 32'h0005_0022, "R9");
        chk("R9", "edge pending cleared", 64'(raise_stb), 64'h0);

        // Masked edge keeps pending; unmasking write delivers.
        wr_dst(1, 32'h2, "R6");
        wr_vp(1, 32'h8003_0011, "R6");
        set_irq(1, 1, "R6");
        set_irq(1, 0, "R5");
        chk("R6", "masked no raise", 64'(raised[NS+1]), 64'h0);
        wr_vp(1, 32'h0003_0011, "R8");
        chk("R8", "unmask delivers", 64'(raise_stb), 64'h2);

        // Task priority boundary.
        task_prio = {4'd2, 4'd3};
        wr_dst(0, 32'h3, "R7");
        wr_vp(0, 32'h0003_0001, "R7");
        set_irq(0, 1, "R7");
        chk("R7", "equal prio dropped", 64'(raised[0]), 64'h0);
        chk("R7", "higher prio taken", 64'(raised[NS]), 64'h1);
        task_prio = '0;

        // Zero priority and empty destination.
        wr_dst(9, 32'h1, "R6");
        wr_vp(9, 32'h0000_0099, "R6");
        set_irq(9, 1, "R6");
        chk("R6", "zero prio", 64'(raise_stb), 64'h0);
        wr_vp(10, 32'h0001_0000, "R6");
        set_irq(10, 1, "R6");
        chk("R6", "no target", 64'(raise_stb), 64'h0);

        // Level source 4.
        wr_dst(4, 32'h1, "R4");
        wr_vp(4, 32'h0007_0044, "R4");
        set_irq(4, 1, "R4");
        chk("R4", "level raise", 64'(raised[4]), 64'h1);
        ack(0, 4, "R9");
        peek(0, 4, "R9");
        chk("R9", "level activity kept", 64'(cfg_rdata), 64'h6047_0044);
        wr_vp(4, 32'h0007_0044, "R6");
        chk("R6", "level active no raise", 64'(raise_stb), 64'h0);
        set_irq(4, 0, "R4");
        chk("R4", "fall clears activity", 64'(cfg_rdata), 64'h2047_0044);
        set_irq(4, 1, "R4");
        chk("R4", "level re-raise", 64'(raise_stb), 64'h1);

        // R8: only input change or vector write triggers.
        wr_vp(6, 32'h0002_0066, "R8");
        set_irq(6, 1, "R8");
        wr_dst(6, 32'h1, "R8");
        chk("R8", "dst write no trigger", 64'(raised[6]), 64'h0);
        wr_vp(6, 32'h0002_0066, "R8");
        chk("R8", "vp write triggers", 64'(raised[6]), 64'h1);

        // R7: already raised at the CPU.
        wr_dst(12, 32'h1, "R7");
        wr_vp(12, 32'h0004_0000, "R7");
        set_irq(12, 1, "R7");
        set_irq(12, 0, "R7");
        set_irq(12, 1, "R7");
        chk("R7", "already raised dropped", 64'(raise_stb), 64'h0);

        // Random mix checked against the reference model.
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 3 == 0) irq_in[$urandom % NS] ^= 1'b1;
            if ($urandom % 4 == 0) begin
                cfg_we = 1;
                cfg_dst_sel = ($urandom % 3 == 0);
                cfg_wdata = $urandom;
                if ($urandom % 4 != 0) cfg_wdata[31] = 1'b0;
            end
            cfg_idx = IW'($urandom % NS);
            if ($urandom % 4 == 0) begin
                ack_valid = 1; ack_cpu = CW'($urandom % NC); ack_src = IW'($urandom % NS);
            end
            if ($urandom % 16 == 0) task_prio = NC*4'($urandom);
            step("R7 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule